// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-on to normal operation by driving its command pins (chip select, row strobe, column strobe, write enable, bank and address lines) through a fixed bring-up order. On a start pulse it sends one NOP so the device clock is running. It then waits a stabilization pause of `CLK_MHZ * PAUSE_US` cycles and issues a precharge to all banks. Eight auto-refresh commands follow, then a mode-register load carrying CAS latency, burst type and burst length. Consecutive commands are separated by programmable gaps.

After the mode load the sequencer enters normal mode and raises `init_done`. From then on a programmable interval timer counts refresh periods. Each expiry adds one to a pending count. While any refresh is pending, the block raises `refresh_req` toward the access arbiter. When `refresh_gnt` is high, it issues an auto-refresh and takes one from the count, so expiries that occur while the grant is held back are not lost.

States and transitions: `ST_IDLE` goes to `ST_CLKNOP` on start. `ST_CLKNOP` goes to `ST_PAUSE`, which goes to `ST_PREALL` on timer expiry. `ST_PREALL` goes to `ST_WAIT_RP`, which goes to `ST_INIT_REF` on expiry. `ST_INIT_REF` goes to `ST_WAIT_RC`. On expiry, `ST_WAIT_RC` goes back to `ST_INIT_REF`, or to `ST_LOADMODE` once eight refreshes are done. `ST_LOADMODE` goes to `ST_WAIT_MRD`, which goes to `ST_NORMAL` on expiry. `ST_NORMAL` goes to `ST_AUTO_REF` when a refresh is pending and granted. `ST_AUTO_REF` goes to `ST_AUTO_RC`, which returns to `ST_NORMAL` on expiry.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset until start is seen, the bus shows command inhibit (all four strobes high), and `init_done` and `refresh_req` are low.
- R2: The first command after a start pulse is a NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), driven in the cycle after the one in which start is sampled high.
- R3: A precharge (cs_n=0, ras_n=0, cas_n=1, we_n=0) with address bit 10 set comes exactly `CLK_MHZ*PAUSE_US` cycles after the NOP. Only NOPs are driven in between.
- R4: Exactly eight auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) follow the precharge. The first comes max(t_rp,2) cycles after the precharge, and each later one comes max(t_rc,2) cycles after the one before.
- R5: A mode load (all four strobes low) comes max(t_rc,2) cycles after the eighth refresh. Its address carries burst_len on bits 2:0, burst_seq on bit 3 and cas_lat on bits 6:4, with all other address bits zero and the bank lines zero.
- R6: `init_done` rises exactly two cycles after the mode load and then stays high.
- R7: With the grant held high, the first periodic refresh command comes ref_period+1 cycles after `init_done` rises. Later ones follow every ref_period cycles.
- R8: While `refresh_gnt` is low, no refresh command is issued and a raised `refresh_req` stays high.
- R9: Every expiry that passes while the grant is withheld is later served. After the grant returns, the first refresh comes in the next cycle and the rest follow max(t_rc,2)+1 cycles apart. `refresh_req` then drops.
- R10: A start pulse outside `ST_IDLE` is ignored: it neither restarts nor shifts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin bring-up (honoured in idle only) |
| cas_lat | input | 3 | CAS latency code for the mode load |
| burst_len | input | 3 | Burst length code for the mode load |
| burst_seq | input | 1 | Burst type bit for the mode load |
| t_rp | input | GAP_W | Cycles from precharge to next command |
| t_rc | input | GAP_W | Cycles from a refresh to next command |
| ref_period | input | PERIOD_W | Cycles between periodic refresh expiries |
| refresh_gnt | input | 1 | Arbiter permits a refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_a | output | ADDR_W | Address lines |
| init_done | output | 1 | Bring-up complete, normal mode |
| refresh_req | output | 1 | A periodic refresh is pending |

## Verification
The bound checker watches several properties on every cycle:
- exactly eight boot refreshes come before the mode load;
- the mode load carries zero bank lines and zero upper address bits;
- the precharge has bit 10 set;
- `init_done` rises two cycles after the mode load and never falls;
- a pending request is held while the grant is low;
- no normal-mode refresh appears without a granted request in the cycle before.

Exact cycle distances can only be shown by the bench's timestamped command log, because they depend on the gap inputs and the pause length. These include the pause, each t_rp/t_rc gap, the periodic spacing and the serving of withheld expiries. The same holds for ignoring a stray start pulse.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLKNOP,
        ST_PAUSE,
        ST_PREALL,
        ST_WAIT_RP,
        ST_INIT_REF,
        ST_WAIT_RC,
        ST_LOADMODE,
        ST_WAIT_MRD,
        ST_NORMAL,
        ST_AUTO_REF,
        ST_AUTO_RC
    } seq_state_e;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int PERIOD_W = 16,
    parameter int PEND_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic                take,
    output logic                pending_nz
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    logic [PERIOD_W-1:0] cnt;
    logic [PEND_W-1:0]   pend;
    logic                tick;

    assign tick = enable && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || cnt == '0) begin
            cnt <= period - 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (pend != PEND_MAX) pend <= pend + 1'b1;
                2'b01:   if (pend != '0) pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    assign pending_nz = (pend != '0);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ  = 50,
    parameter int PAUSE_US = 200,
    parameter int ADDR_W   = 13,
    parameter int BANK_W   = 2,
    parameter int GAP_W    = 4,
    parameter int PERIOD_W = 16,
    parameter int PEND_W   = 4,
    parameter int PRE_BIT  = 10,
    parameter int BOOT_REFS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          cas_lat,
    input  logic [2:0]          burst_len,
    input  logic                burst_seq,
    input  logic [GAP_W-1:0]    t_rp,
    input  logic [GAP_W-1:0]    t_rc,
    input  logic [PERIOD_W-1:0] ref_period,
    input  logic                refresh_gnt,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0]   sd_a,
    output logic                init_done,
    output logic                refresh_req
);
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int PAUSE_W   = $clog2(PAUSE_CYC + 1);
    localparam int CNT_W     = (PAUSE_W > GAP_W + 1) ? PAUSE_W : GAP_W + 1;
    localparam int RC_W      = $clog2(BOOT_REFS + 1);

    seq_state_e       state, state_nx;
    sd_cmd_e          cmd;
    logic [RC_W-1:0]  boot_cnt;
    logic             tmr_load, tmr_exp, pend_nz;
    logic [CNT_W-1:0] tmr_val;

    // spacing between two commands is max(g,2) cycles
    function automatic logic [CNT_W-1:0] gap_load(input logic [GAP_W-1:0] g);
        if (g < GAP_W'(2)) return '0;
        return CNT_W'(g) - CNT_W'(2);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) boot_cnt <= '0;
        else if (state == ST_INIT_REF)  boot_cnt <= boot_cnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_CLKNOP;
            ST_CLKNOP:   state_nx = ST_PAUSE;
            ST_PAUSE:    if (tmr_exp) state_nx = ST_PREALL;
            ST_PREALL:   state_nx = ST_WAIT_RP;
            ST_WAIT_RP:  if (tmr_exp) state_nx = ST_INIT_REF;
            ST_INIT_REF: state_nx = ST_WAIT_RC;
            ST_WAIT_RC:  if (tmr_exp)
                             state_nx = (boot_cnt == RC_W'(BOOT_REFS)) ? ST_LOADMODE : ST_INIT_REF;
            ST_LOADMODE: state_nx = ST_WAIT_MRD;
            ST_WAIT_MRD: if (tmr_exp) state_nx = ST_NORMAL;
            ST_NORMAL:   if (pend_nz && refresh_gnt) state_nx = ST_AUTO_REF;
            ST_AUTO_REF: state_nx = ST_AUTO_RC;
            ST_AUTO_RC:  if (tmr_exp) state_nx = ST_NORMAL;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = 1'b1;
        unique case (state)
            ST_CLKNOP:                tmr_val = CNT_W'(PAUSE_CYC - 2);
            ST_PREALL:                tmr_val = gap_load(t_rp);
            ST_INIT_REF, ST_AUTO_REF: tmr_val = gap_load(t_rc);
            ST_LOADMODE:              tmr_val = '0;
            default: begin
                tmr_load = 1'b0;
                tmr_val  = '0;
            end
        endcase
    end

    sdram_gap_timer #(.CW(CNT_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    sdram_refresh_timer #(.PERIOD_W(PERIOD_W), .PEND_W(PEND_W)) u_rtmr (
        .clk(clk), .rst_n(rst_n), .enable(init_done), .period(ref_period),
        .take(state == ST_AUTO_REF), .pending_nz(pend_nz)
    );

    always_comb begin
        cmd         = CMD_NOP;
        sd_ba       = '0;
        sd_a        = '0;
        init_done   = 1'b0;
        refresh_req = 1'b0;
        unique case (state)
            ST_IDLE:     cmd = CMD_INH;
            ST_PREALL: begin
                cmd           = CMD_PRE;
                sd_a[PRE_BIT] = 1'b1;
            end
            ST_INIT_REF: cmd = CMD_REF;
            ST_LOADMODE: begin
                cmd       = CMD_MRS;
                sd_a[2:0] = burst_len;
                sd_a[3]   = burst_seq;
                sd_a[6:4] = cas_lat;
            end
            ST_NORMAL: begin
                init_done   = 1'b1;
                refresh_req = pend_nz;
            end
            ST_AUTO_REF: begin
                cmd       = CMD_REF;
                init_done = 1'b1;
            end
            ST_AUTO_RC:  init_done = 1'b1;
            default:     cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W  = 13,
    parameter int BANK_W  = 2,
    parameter int PRE_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ADDR_W-1:0] sd_a,
    input logic              init_done,
    input logic              refresh_req,
    input logic              refresh_gnt
);
    logic [3:0] cmdv;
    logic       is_ref, is_mrs, is_pre;
    logic [3:0] boot_refs;

    assign cmdv   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_ref = (cmdv == 4'b0001);
    assign is_mrs = (cmdv == 4'b0000);
    assign is_pre = (cmdv == 4'b0010);

    always_ff @(posedge clk) begin
        if (!rst_n) boot_refs <= '0;
        else if (is_ref && !init_done && boot_refs != 4'hF) boot_refs <= boot_refs + 1'b1;
    end

    a_r4_eight_boot_refs: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (boot_refs == 4'd8));

    a_r5_mode_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (sd_ba == '0 && sd_a[ADDR_W-1:7] == '0));

    a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_a[PRE_BIT]);

    a_r6_done_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(is_mrs, 2));

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r1_req_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> init_done);

    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && !refresh_gnt) |=> refresh_req);

    a_r8_ref_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && init_done && $past(init_done)) |-> $past(refresh_req && refresh_gnt));
endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PRE_BIT(PRE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
    .init_done(init_done), .refresh_req(refresh_req), .refresh_gnt(refresh_gnt)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
    localparam int PAUSE = 100;   // 50 MHz * 2 us
    localparam int TRP   = 3;
    localparam int TRC   = 5;
    localparam int PER   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        refresh_gnt = 1'b1;
    logic        cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
    logic [1:0]  ba;
    logic [12:0] a;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_log = 0, first_nop = -1, done_cyc = -1;
    int        log_cyc [64];
    logic [3:0]  log_cmd [64];
    logic [12:0] log_a [64];
    logic [1:0]  log_ba [64];
    bit finished = 0;

    always #10 clk = ~clk;

    sdram_init_seq #(.PAUSE_US(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cas_lat(3'd3), .burst_len(3'd3),
        .burst_seq(1'b0), .t_rp(4'(TRP)), .t_rc(4'(TRC)), .ref_period(16'(PER)),
        .refresh_gnt(refresh_gnt), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
        .sd_we_n(we_n), .sd_ba(ba), .sd_a(a), .init_done(init_done), .refresh_req(refresh_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] c;
            c = {cs_n, ras_n, cas_n, we_n};
            if (c == 4'b0111 && first_nop < 0) first_nop = cyc;
            if (init_done && done_cyc < 0) done_cyc = cyc;
            if ((c == 4'b0010 || c == 4'b0001 || c == 4'b0000) && n_log < 64) begin
                log_cyc[n_log] = cyc;
                log_cmd[n_log] = c;
                log_a[n_log]   = a;
                log_ba[n_log]  = ba;
                n_log++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        repeat (3) step();
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            check({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1 inhibit", int'({cs_n, ras_n, cas_n, we_n}), 15);
        end
        check(!init_done, "R1 init_done", int'(init_done), 0);
        check(!refresh_req, "R1 refresh_req", int'(refresh_req), 0);
    endtask

    task automatic t_bringup();
        int s;
        s = cyc;
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (30) step();
        start = 1'b1;                 // R10: stray pulse during the pause
        step();
        start = 1'b0;
        for (int i = 0; i < 2000 && !init_done; i++) step();
        check(first_nop == s + 1, "R2 NOP cycle", first_nop, s + 1);
        check(log_cmd[0] == 4'b0010, "R3 precharge first", int'(log_cmd[0]), 2);
        check(log_cyc[0] - first_nop == PAUSE, "R3 pause length", log_cyc[0] - first_nop, PAUSE);
        check(log_a[0][10], "R3 all-banks bit", int'(log_a[0][10]), 1);
        for (int k = 1; k <= 8; k++) begin
            int gap;
            gap = (k == 1) ? TRP : TRC;
            check(log_cmd[k] == 4'b0001, "R4 refresh code", int'(log_cmd[k]), 1);
            check(log_cyc[k] - log_cyc[k-1] == gap, "R4 refresh gap", log_cyc[k] - log_cyc[k-1], gap);
        end
        check(log_cmd[9] == 4'b0000, "R5 mode load code", int'(log_cmd[9]), 0);
        check(log_cyc[9] - log_cyc[8] == TRC, "R5 mode gap", log_cyc[9] - log_cyc[8], TRC);
        check(log_a[9] == 13'd51, "R5 mode fields", int'(log_a[9]), 51);
        check(log_ba[9] == 2'd0, "R5 bank zero", int'(log_ba[9]), 0);
        check(done_cyc == log_cyc[9] + 2, "R6 done timing", done_cyc, log_cyc[9] + 2);
        check(n_log == 10, "R10 single sequence", n_log, 10);
    endtask

    task automatic t_periodic();
        for (int i = 0; i < 500 && n_log < 13; i++) step();
        check(log_cyc[10] == done_cyc + PER + 1, "R7 first refresh", log_cyc[10], done_cyc + PER + 1);
        check(log_cyc[11] - log_cyc[10] == PER, "R7 spacing a", log_cyc[11] - log_cyc[10], PER);
        check(log_cyc[12] - log_cyc[11] == PER, "R7 spacing b", log_cyc[12] - log_cyc[11], PER);
        for (int i = 10; i < 13; i++)
            check(init_done, "R6 done stays", int'(init_done), 1);
    endtask

    task automatic t_withheld();
        int n0, g;
        refresh_gnt = 1'b0;
        n0 = n_log;
        repeat (3 * PER + 5) step();
        check(n_log == n0, "R8 no refresh without grant", n_log - n0, 0);
        check(refresh_req, "R8 request held", int'(refresh_req), 1);
        g = cyc;
        refresh_gnt = 1'b1;
        repeat (20) step();
        check(n_log == n0 + 3, "R9 all expiries served", n_log - n0, 3);
        check(log_cyc[n0] == g + 1, "R9 first after grant", log_cyc[n0], g + 1);
        check(log_cyc[n0+1] - log_cyc[n0] == TRC + 1, "R9 burst spacing a", log_cyc[n0+1] - log_cyc[n0], TRC + 1);
        check(log_cyc[n0+2] - log_cyc[n0+1] == TRC + 1, "R9 burst spacing b", log_cyc[n0+2] - log_cyc[n0+1], TRC + 1);
        check(!refresh_req, "R9 request drops", int'(refresh_req), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        summary();
    end

    initial begin
        t_reset_state();
        t_bringup();
        t_periodic();
        t_withheld();
        summary();
    end
endmodule